// File: doc/BRIEF.md
# GPIO Port Controller with Pin Interrupts

This block controls one port of up to eight general-purpose pins. Each pin has its own small register window. Through it software enables the pin, chooses input or output direction, lets the output driver float, sets the output level, reads back the filtered input level, sets a debounce threshold and picks an interrupt trigger. A status word gathers the pending interrupt bits of every pin in the port. One interrupt line goes high when any pending pin also has its interrupt enable set.

On the input side every pin goes through a two-flop synchroniser and then a debounce filter. The filter is a two-state machine. In DB_STEADY the filtered level is settled. The transition STEADY->QUALIFY happens when the synchronised input first differs from the filtered level. QUALIFY->STEADY (bounce) happens when the input returns to the filtered level. QUALIFY->STEADY (accept) happens when the difference has been seen on the threshold's number of consecutive clock edges; on that edge the filtered level takes the new value.

The filtered level feeds a trigger detector with a second two-state machine. PD_IDLE->PD_PENDING is the transition "hit". PD_PENDING->PD_IDLE is the transition "clear", taken only on a clear write in a cycle with no hit. The bus is word addressed with single-cycle writes and a combinational read.

Top module: `gpiop_port`

## Requirements
- R1: A synchronous reset sets every register and pending bit to zero. In the cycle after reset, pin_oe, pin_out and irq are all zero and every register reads zero.
- R2: Word address bit 6 clear selects a pin window: bits 5:3 give the pin and bits 2:0 give the register (0 config, 1 debounce, 2 input, 3 output control, 4 output value, 5 clear; 6 and 7 read zero). The config register keeps bit 0 pin enable, bit 1 output direction, bits 3:2 trigger type, bit 4 polarity and bit 6 interrupt enable. The debounce register keeps bits 7:0. All other bits read zero.
- R3: pin_oe of a pin is high only when it is enabled, set as an output (config bit 1) and not floated (output control bit 0 clear). pin_out then equals output value bit 0, and it is zero while pin_oe is low.
- R4: With a threshold of zero, input register bit 0 follows pin_in two clock edges after pin_in changes.
- R5: With a nonzero threshold N, the filtered level changes only on the Nth consecutive edge at which the synchronised input differs from it. A shorter pulse leaves the input register and the triggers unaffected.
- R6: Trigger type 1 (level) with polarity 1 or 0 sets the pending bit on every cycle in which the filtered level is high or low, respectively. A clear written while that level lasts has no effect.
- R7: Trigger type 2 (single edge) sets pending on a rising filtered edge when polarity is 1 and on a falling edge when it is 0. Type 3 sets it on either edge whatever the polarity.
- R8: A pending bit stays set until a write with bit 0 = 1 to that pin's clear register. A clear write with bit 0 = 0 does nothing. A trigger hit in the same cycle as a clear wins.
- R9: Trigger type 0, or a clear enable bit, never sets the pending bit.
- R10: Any word with address bit 6 set (byte offset 0x100 + 4k) reads the port status, with bit n equal to the pending bit of pin n.
- R11: irq is high exactly when some pin is both pending and has config bit 6 set. The interrupt enable does not gate the pending bit.
- R12: Writes to the input register, the status words or registers 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (7) | Word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| pin_in | input | NPINS (8) | Pin input levels, asynchronous |
| pin_out | output | NPINS (8) | Pin output levels |
| pin_oe | output | NPINS (8) | Pin output driver enables |
| irq | output | 1 | Combined port interrupt |

## Verification
A debounce machine that is stuck or miscounting shows up at the input register, and later at irq, one edge earlier or later than the reference expects. A lost or stuck pending state shows on the status word and on irq in the first cycle after the hit or clear edge. A wrong latch in a config field appears on pin_oe, pin_out or the read data on the cycle after the write. The reference model is compared against irq, pin_oe, pin_out and the read data on every clock, so most faults are reported within one to three cycles of the stimulus that exposes them.

// File: rtl/gpiop_pkg.sv
`timescale 1ns/1ps
package gpiop_pkg;

    // log2 of the number of words in one pin window
    localparam int WIN_W = 3;

    localparam logic [WIN_W-1:0] RG_CFG  = 3'd0;
    localparam logic [WIN_W-1:0] RG_DEB  = 3'd1;
    localparam logic [WIN_W-1:0] RG_INP  = 3'd2;
    localparam logic [WIN_W-1:0] RG_OCTL = 3'd3;
    localparam logic [WIN_W-1:0] RG_OVAL = 3'd4;
    localparam logic [WIN_W-1:0] RG_CLR  = 3'd5;

    localparam int CF_EN   = 0;
    localparam int CF_DIR  = 1;
    localparam int CF_TRIG = 2;
    localparam int CF_POL  = 4;
    localparam int CF_IE   = 6;

    typedef enum logic [1:0] {
        TRIG_OFF   = 2'd0,
        TRIG_LEVEL = 2'd1,
        TRIG_EDGE  = 2'd2,
        TRIG_BOTH  = 2'd3
    } trig_e;

    typedef struct packed {
        logic  ie;
        logic  pol;
        trig_e trig;
        logic  dir;
        logic  en;
    } pin_cfg_t;

endpackage

// File: rtl/gpiop_debounce.sv
`timescale 1ns/1ps
module gpiop_debounce #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic [THR_W-1:0] thr,
    output logic             level
);
    typedef enum logic {
        DB_STEADY,
        DB_QUALIFY
    } db_state_e;

    db_state_e        state_q, state_d;
    logic             held_q, held_d;
    logic [THR_W-1:0] run_q, run_d;
    logic             bypass;
    logic             differs;
    logic             reached;

    assign bypass  = (thr == '0);
    assign differs = (raw != held_q);
    assign reached = ({1'b0, run_q} + 1'b1) == {1'b0, thr};

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DB_STEADY;
            held_q  <= 1'b0;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
            run_q   <= run_d;
        end
    end

    // next state and counter
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        run_d   = run_q;
        if (bypass) begin
            state_d = DB_STEADY;
            held_d  = raw;
            run_d   = '0;
        end else begin
            unique case (state_q)
                DB_STEADY: begin
                    if (differs) begin
                        if (reached) begin
                            held_d = raw;
                        end else begin
                            state_d = DB_QUALIFY;
                            run_d   = run_q + 1'b1;
                        end
                    end
                end
                DB_QUALIFY: begin
                    if (!differs) begin
                        state_d = DB_STEADY;
                        run_d   = '0;
                    end else if (reached) begin
                        state_d = DB_STEADY;
                        held_d  = raw;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
                default: begin
                    state_d = DB_STEADY;
                    run_d   = '0;
                end
            endcase
        end
    end

    // output
    always_comb begin
        level = bypass ? raw : held_q;
    end

endmodule

// File: rtl/gpiop_trigger.sv
`timescale 1ns/1ps
module gpiop_trigger
    import gpiop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  level,
    input  logic  en,
    input  trig_e trig,
    input  logic  pol,
    input  logic  clr,
    output logic  pend,
    output logic  hit
);
    typedef enum logic {
        PD_IDLE,
        PD_PENDING
    } pd_state_e;

    pd_state_e state_q, state_d;
    logic      level_q;
    logic      rise;
    logic      fall;
    logic      cond;

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;

    always_comb begin
        unique case (trig)
            TRIG_OFF:   cond = 1'b0;
            TRIG_LEVEL: cond = (level == pol);
            TRIG_EDGE:  cond = pol ? rise : fall;
            TRIG_BOTH:  cond = rise | fall;
            default:    cond = 1'b0;
        endcase
        hit = en & cond;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PD_IDLE;
            level_q <= 1'b0;
        end else begin
            state_q <= state_d;
            level_q <= level;
        end
    end

    // next state: a hit has priority over a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE:    if (hit) state_d = PD_PENDING;
            PD_PENDING: if (clr && !hit) state_d = PD_IDLE;
            default:    state_d = PD_IDLE;
        endcase
    end

    // output
    always_comb begin
        pend = (state_q == PD_PENDING);
    end

endmodule

// File: rtl/gpiop_pin.sv
`timescale 1ns/1ps
module gpiop_pin
    import gpiop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_wr,
    input  logic [WIN_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              en,
    output logic              ie,
    output logic              pend,
    output logic              hit,
    output logic              clr
);
    pin_cfg_t         cfg_q;
    logic [THR_W-1:0] thr_q;
    logic             flt_q;
    logic             oval_q;
    logic             sync1_q;
    logic             sync2_q;
    logic             level;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            thr_q  <= '0;
            flt_q  <= 1'b0;
            oval_q <= 1'b0;
        end else if (sel_wr) begin
            unique case (reg_sel)
                RG_CFG: begin
                    cfg_q.en   <= wdata[CF_EN];
                    cfg_q.dir  <= wdata[CF_DIR];
                    cfg_q.trig <= trig_e'(wdata[CF_TRIG +: 2]);
                    cfg_q.pol  <= wdata[CF_POL];
                    cfg_q.ie   <= wdata[CF_IE];
                end
                RG_DEB:  thr_q  <= wdata[THR_W-1:0];
                RG_OCTL: flt_q  <= wdata[0];
                RG_OVAL: oval_q <= wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
        end
    end

    gpiop_debounce #(.THR_W(THR_W)) u_debounce (
        .clk   (clk),
        .rst   (rst),
        .raw   (sync2_q),
        .thr   (thr_q),
        .level (level)
    );

    assign clr = sel_wr && (reg_sel == RG_CLR) && wdata[0];

    gpiop_trigger u_trigger (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .en    (cfg_q.en),
        .trig  (cfg_q.trig),
        .pol   (cfg_q.pol),
        .clr   (clr),
        .pend  (pend),
        .hit   (hit)
    );

    assign en      = cfg_q.en;
    assign ie      = cfg_q.ie;
    assign pin_oe  = cfg_q.en & cfg_q.dir & ~flt_q;
    assign pin_out = pin_oe & oval_q;

    always_comb begin
        rdata = '0;
        unique case (reg_sel)
            RG_CFG: begin
                rdata[CF_EN]         = cfg_q.en;
                rdata[CF_DIR]        = cfg_q.dir;
                rdata[CF_TRIG +: 2]  = cfg_q.trig;
                rdata[CF_POL]        = cfg_q.pol;
                rdata[CF_IE]         = cfg_q.ie;
            end
            RG_DEB:  rdata[THR_W-1:0] = thr_q;
            RG_INP:  rdata[0] = level;
            RG_OCTL: rdata[0] = flt_q;
            RG_OVAL: rdata[0] = oval_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpiop_port.sv
`timescale 1ns/1ps
module gpiop_port
    import gpiop_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam int PIN_W = ADDR_W - 1 - WIN_W;
    localparam int SLOTS = 1 << PIN_W;

    logic              status_sel;
    logic [PIN_W-1:0]  pin_idx;
    logic [WIN_W-1:0]  reg_idx;
    logic [DATA_W-1:0] rdata_arr [SLOTS];
    logic [NPINS-1:0]  pend_vec;
    logic [NPINS-1:0]  hit_vec;
    logic [NPINS-1:0]  clr_vec;
    logic [NPINS-1:0]  en_vec;
    logic [NPINS-1:0]  ie_vec;
    logic [DATA_W-1:0] status_word;

    assign status_sel = bus_addr[ADDR_W-1];
    assign pin_idx    = bus_addr[WIN_W +: PIN_W];
    assign reg_idx    = bus_addr[WIN_W-1:0];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NPINS) begin : g_pin
            logic sel_wr;
            assign sel_wr = bus_wr && !status_sel && (pin_idx == PIN_W'(g));
            gpiop_pin #(.DATA_W(DATA_W), .THR_W(THR_W)) u_pin (
                .clk     (clk),
                .rst     (rst),
                .sel_wr  (sel_wr),
                .reg_sel (reg_idx),
                .wdata   (bus_wdata),
                .rdata   (rdata_arr[g]),
                .pin_in  (pin_in[g]),
                .pin_out (pin_out[g]),
                .pin_oe  (pin_oe[g]),
                .en      (en_vec[g]),
                .ie      (ie_vec[g]),
                .pend    (pend_vec[g]),
                .hit     (hit_vec[g]),
                .clr     (clr_vec[g])
            );
        end else begin : g_empty
            assign rdata_arr[g] = '0;
        end
    end

    assign status_word = {{(DATA_W-NPINS){1'b0}}, pend_vec};
    assign bus_rdata   = status_sel ? status_word : rdata_arr[pin_idx];
    assign irq         = |(pend_vec & ie_vec);

endmodule

// File: rtl/gpiop_port_checker.sv
`timescale 1ns/1ps
module gpiop_port_checker #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] pend,
    input logic [NPINS-1:0] hit,
    input logic [NPINS-1:0] clr,
    input logic [NPINS-1:0] en
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!irq && pin_oe == '0))
        else $error("reset did not quiet the port outputs");

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (pend[g] && !clr[g]) |=> pend[g])
            else $error("pending bit dropped without a clear");

        assert_clear_takes_R8: assert property (@(posedge clk) disable iff (rst)
            (clr[g] && !hit[g]) |=> !pend[g])
            else $error("clear without hit left pending set");

        assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (rst)
            (!en[g] && !pend[g]) |=> !pend[g])
            else $error("disabled pin raised pending");
    end

endmodule

bind gpiop_port gpiop_port_checker #(.NPINS(NPINS)) u_checker (
    .clk    (clk),
    .rst    (rst),
    .irq    (irq),
    .pin_oe (pin_oe),
    .pend   (pend_vec),
    .hit    (hit_vec),
    .clr    (clr_vec),
    .en     (en_vec)
);

// File: tb/gpiop_port_bench.sv
`timescale 1ns/1ps
module gpiop_port_bench;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    gpiop_port u_gpiop_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // reference model state
    int m_s1[NP], m_s2[NP], m_held[NP], m_run[NP], m_qual[NP], m_lq[NP], m_pend[NP];
    int m_en[NP], m_dir[NP], m_trig[NP], m_pol[NP], m_ie[NP], m_thr[NP], m_flt[NP], m_oval[NP];

    function automatic int m_level(int p);
        return (m_thr[p] == 0) ? m_s2[p] : m_held[p];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            started = 1;
            for (int p = 0; p < NP; p++) begin
                m_s1[p] = 0; m_s2[p] = 0; m_held[p] = 0; m_run[p] = 0; m_qual[p] = 0;
                m_lq[p] = 0; m_pend[p] = 0; m_en[p] = 0; m_dir[p] = 0; m_trig[p] = 0;
                m_pol[p] = 0; m_ie[p] = 0; m_thr[p] = 0; m_flt[p] = 0; m_oval[p] = 0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                int lvl, cond, hit, pw, clr;
                lvl = m_level(p);
                case (m_trig[p])
                    1: cond = (lvl == m_pol[p]) ? 1 : 0;
                    2: cond = m_pol[p] != 0 ? ((lvl == 1 && m_lq[p] == 0) ? 1 : 0)
                                            : ((lvl == 0 && m_lq[p] == 1) ? 1 : 0);
                    3: cond = (lvl != m_lq[p]) ? 1 : 0;
                    default: cond = 0;
                endcase
                hit = (m_en[p] != 0 && cond != 0) ? 1 : 0;
                pw  = (bus_wr && !bus_addr[6] && bus_addr[5:3] == 3'(p)) ? 1 : 0;
                clr = (pw != 0 && bus_addr[2:0] == 3'd5 && bus_wdata[0]) ? 1 : 0;
                if (hit != 0) m_pend[p] = 1;
                else if (clr != 0) m_pend[p] = 0;
                if (m_thr[p] == 0) begin
                    m_held[p] = m_s2[p]; m_qual[p] = 0; m_run[p] = 0;
                end else if (m_s2[p] == m_held[p]) begin
                    m_qual[p] = 0; m_run[p] = 0;
                end else if (m_run[p] + 1 == m_thr[p]) begin
                    m_held[p] = m_s2[p]; m_qual[p] = 0; m_run[p] = 0;
                end else begin
                    m_qual[p] = 1; m_run[p] = (m_run[p] + 1) & 255;
                end
                m_lq[p] = lvl;
                m_s2[p] = m_s1[p];
                m_s1[p] = pin_in[p];
                if (pw != 0) begin
                    case (bus_addr[2:0])
                        3'd0: begin
                            m_en[p] = bus_wdata[0]; m_dir[p] = bus_wdata[1];
                            m_trig[p] = int'(bus_wdata[3:2]); m_pol[p] = bus_wdata[4];
                            m_ie[p] = bus_wdata[6];
                        end
                        3'd1: m_thr[p] = int'(bus_wdata[7:0]);
                        3'd3: m_flt[p] = bus_wdata[0];
                        3'd4: m_oval[p] = bus_wdata[0];
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] v = '0;
        for (int p = 0; p < NP; p++) v[p] = (m_en[p] != 0 && m_dir[p] != 0 && m_flt[p] == 0);
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] v = '0;
        for (int p = 0; p < NP; p++) v[p] = (m_en[p] != 0 && m_dir[p] != 0 && m_flt[p] == 0 && m_oval[p] != 0);
        return v;
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] v = '0;
        for (int p = 0; p < NP; p++) v[p] = (m_pend[p] != 0);
        return v;
    endfunction

    function automatic logic exp_irq();
        logic v = 1'b0;
        for (int p = 0; p < NP; p++) if (m_pend[p] != 0 && m_ie[p] != 0) v = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(logic [6:0] a);
        int p;
        if (a[6]) return exp_status();
        p = int'(a[5:3]);
        case (a[2:0])
            3'd0: return 32'(m_en[p] + 2 * m_dir[p] + 4 * m_trig[p] + 16 * m_pol[p] + 64 * m_ie[p]);
            3'd1: return 32'(m_thr[p]);
            3'd2: return 32'(m_level(p));
            3'd3: return 32'(m_flt[p]);
            3'd4: return 32'(m_oval[p]);
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            chk(phase, "irq", 32'(irq), 32'(exp_irq()));
            chk(phase, "pin_oe", 32'(pin_oe), 32'(exp_oe()));
            chk(phase, "pin_out", 32'(pin_out), 32'(exp_out()));
            chk(phase, "rdata", bus_rdata, exp_rd(bus_addr));
        end
    end

    function automatic logic [6:0] ad(int p, int r);
        return 7'(p * 8 + r);
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(string tag, logic [6:0] a, logic [31:0] exp);
        bus_addr = a;
        @(negedge clk);
        chk(tag, "read", bus_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic irq_chk(string tag, logic exp);
        @(negedge clk);
        chk(tag, "irq", 32'(irq), 32'(exp));
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1 reset
        tick(3);
        @(negedge clk);
        chk("R1", "irq", 32'(irq), 32'd0);
        chk("R1", "pin_oe", 32'(pin_oe), 32'd0);
        rst = 1'b0;
        tick(1);
        rd_chk("R1", ad(3, 0), 32'd0);

        // R2 register layout
        phase = "R2";
        wr(ad(3, 0), 32'hFFFF_FFFF);
        rd_chk("R2", ad(3, 0), 32'h0000_005F);
        wr(ad(3, 1), 32'h0000_1234);
        rd_chk("R2", ad(3, 1), 32'h0000_0034);
        rd_chk("R2", ad(3, 6), 32'd0);
        wr(ad(3, 0), 32'd0);
        wr(ad(3, 1), 32'd0);

        // R3 output path
        phase = "R3";
        wr(ad(2, 4), 32'd1);
        wr(ad(2, 0), 32'd3);
        @(negedge clk);
        chk("R3", "pin_oe", 32'(pin_oe[2]), 32'd1);
        chk("R3", "pin_out", 32'(pin_out[2]), 32'd1);
        tick(1);
        wr(ad(2, 3), 32'd1);
        @(negedge clk);
        chk("R3", "pin_oe float", 32'(pin_oe[2]), 32'd0);
        chk("R3", "pin_out float", 32'(pin_out[2]), 32'd0);
        tick(1);
        wr(ad(2, 3), 32'd0);
        wr(ad(2, 0), 32'd2);
        @(negedge clk);
        chk("R3", "pin_oe disabled", 32'(pin_oe[2]), 32'd0);
        tick(1);

        // R4 synchroniser latency
        phase = "R4";
        bus_addr = ad(5, 2);
        pin_in[5] = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        chk("R4", "input after 1 edge", bus_rdata, 32'd0);
        @(posedge clk); #1;
        @(negedge clk);
        chk("R4", "input after 2 edges", bus_rdata, 32'd1);
        tick(1);

        // R5 debounce
        phase = "R5";
        wr(ad(6, 1), 32'd4);
        bus_addr = ad(6, 2);
        pin_in[6] = 1'b1; tick(3);
        pin_in[6] = 1'b0; tick(8);
        rd_chk("R5", ad(6, 2), 32'd0);
        pin_in[6] = 1'b1; tick(8);
        rd_chk("R5", ad(6, 2), 32'd1);
        pin_in[6] = 1'b0; tick(4);
        pin_in[6] = 1'b1; tick(10);
        rd_chk("R5", ad(6, 2), 32'd1);

        // R6 level trigger
        phase = "R6";
        wr(ad(1, 0), 32'd85);
        pin_in[1] = 1'b1; tick(4);
        irq_chk("R6", 1'b1);
        wr(ad(1, 5), 32'd1);
        irq_chk("R6", 1'b1);
        pin_in[1] = 1'b0; tick(4);
        irq_chk("R6", 1'b1);
        wr(ad(1, 5), 32'd1);
        irq_chk("R6", 1'b0);
        wr(ad(1, 0), 32'd0);

        // R7 edge triggers
        phase = "R7";
        wr(ad(0, 0), 32'd89);
        pin_in[0] = 1'b1; tick(2); pin_in[0] = 1'b0; tick(5);
        irq_chk("R7", 1'b1);
        wr(ad(0, 5), 32'd1);
        irq_chk("R7", 1'b0);
        wr(ad(0, 0), 32'd73);
        pin_in[0] = 1'b1; tick(5);
        irq_chk("R7", 1'b0);
        pin_in[0] = 1'b0; tick(5);
        irq_chk("R7", 1'b1);
        wr(ad(0, 5), 32'd1);
        wr(ad(0, 0), 32'd77);
        pin_in[0] = 1'b1; tick(5);
        irq_chk("R7", 1'b1);
        wr(ad(0, 5), 32'd1);
        irq_chk("R7", 1'b0);
        pin_in[0] = 1'b0; tick(5);
        irq_chk("R7", 1'b1);

        // R8 clear semantics
        phase = "R8";
        wr(ad(0, 5), 32'd0);
        irq_chk("R8", 1'b1);
        wr(ad(0, 5), 32'd1);
        irq_chk("R8", 1'b0);
        pin_in[0] = 1'b1;
        tick(2);
        wr(ad(0, 5), 32'd1);
        irq_chk("R8", 1'b1);
        wr(ad(0, 5), 32'd1);
        irq_chk("R8", 1'b0);
        wr(ad(0, 0), 32'd0);
        pin_in[0] = 1'b0; tick(4);

        // R9 no trigger / disabled
        phase = "R9";
        wr(ad(4, 0), 32'd65);
        pin_in[4] = 1'b1; tick(4); pin_in[4] = 1'b0; tick(4);
        irq_chk("R9", 1'b0);
        wr(ad(4, 0), 32'd76);
        pin_in[4] = 1'b1; tick(4); pin_in[4] = 1'b0; tick(4);
        irq_chk("R9", 1'b0);
        rd_chk("R9", 7'h41, 32'd0);

        // R10 status word, R11 interrupt mask
        phase = "R10";
        wr(ad(2, 0), 32'd13);
        wr(ad(7, 0), 32'd13);
        pin_in[2] = 1'b1; pin_in[7] = 1'b1; tick(4);
        pin_in[7] = 1'b0; tick(4);
        rd_chk("R10", 7'h41, 32'h0000_0084);
        rd_chk("R10", 7'h40, 32'h0000_0084);
        phase = "R11";
        irq_chk("R11", 1'b0);
        wr(ad(7, 0), 32'd77);
        irq_chk("R11", 1'b1);

        // R12 ignored writes
        phase = "R12";
        wr(7'h41, 32'h0000_0000);
        rd_chk("R12", 7'h41, 32'h0000_0084);
        wr(ad(7, 2), 32'd1);
        rd_chk("R12", ad(7, 2), 32'd0);
        wr(ad(7, 6), 32'hFFFF_FFFF);
        rd_chk("R12", ad(7, 0), 32'd77);
        rd_chk("R12", ad(7, 6), 32'd0);
        tick(2);

        finish_run();
    end

endmodule